// File: doc/BRIEF.md
# Subscriber Line Switch State Control

This block is the digital control core of a subscriber line access switch. Two mode-select inputs pick the state of the line. The states are talk, ringing, test and all-off. The block drives one on/off control for each of four switch groups: the break pair, the ringing return switch, the ringing switch and the test pair.

A latch enable can freeze the selected mode. An active-low kill input and an internal thermal fault input both override the mode, whatever the latch is doing. The ringing switch is never opened by logic alone. Once a turn-off is requested, it stays closed until the next ringing-current zero-crossing strobe. Because of this, a direct ringing-to-talk change gives make-before-break behaviour.

The block is built from three parts. `lsw_latch` holds the mode. `lsw_mode_fsm` is the line-state machine, with the states ST_OFF, ST_TALK, ST_RING, ST_TEST and ST_BLOCKED. `lsw_ring_fsm` is the ringing switch machine, with the states RSW_OPEN, RSW_CLOSED and RSW_DRAIN.

The line-state machine moves to ST_BLOCKED whenever an override is present. Otherwise it moves to the state named by the effective mode. The ringing switch machine moves RSW_OPEN to RSW_CLOSED on a ringing request. It moves RSW_CLOSED to RSW_DRAIN when the request ends without a strobe. It moves RSW_CLOSED or RSW_DRAIN to RSW_OPEN on a strobe with no request. It moves RSW_DRAIN back to RSW_CLOSED when the request returns. Every output is registered, so it reflects the inputs sampled at the previous rising edge.

Top module: `line_switch_ctrl`

## Requirements
- R1: Mode {ring_sel,test_sel} = 2'b10 (ringing) gives brk_on=0, rret_on=1, ring_on=1, tst_on=0 one cycle after it is sampled.
- R2: Mode 2'b00 (talk) gives brk_on=1 with rret_on=0 and tst_on=0; ring_on is 0 unless a deferred turn-off is still pending.
- R3: Mode 2'b11 (all-off) commands every switch off; a ringing switch that was closed stays closed until its deferred turn-off completes.
- R4: Mode 2'b01 (test) gives tst_on=1 with brk_on=0 and rret_on=0.
- R5: With hold_en=0 the latch is transparent: a mode change sampled at one edge appears on the outputs after that edge.
- R6: With hold_en=1 the mode sampled at the last edge where hold_en was 0 is kept, and later mode changes have no effect on the outputs.
- R7: kill_n=0 forces brk_on, rret_on and tst_on off after the next edge and keeps any open switch open, regardless of the mode inputs or hold_en.
- R8: therm_fault=1 acts exactly like kill_n=0, and fault_n is the registered inverse of therm_fault.
- R9: Once ring_on is 1 and ringing is no longer requested, ring_on stays 1 until a cycle in which zc_strobe=1 is sampled, and it is 0 after that edge.
- R10: A direct change from ringing to talk sets brk_on=1 and rret_on=0 at the next edge while ring_on stays 1 (make-before-break).
- R11: During and right after reset all switch controls are 0, fault_n is 1, and the held mode is all-off.
- R12: zc_strobe has no effect when no ringing turn-off is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sel | input | 1 | Mode select, upper bit |
| test_sel | input | 1 | Mode select, lower bit |
| hold_en | input | 1 | 1 freezes the mode, 0 lets it through |
| kill_n | input | 1 | Active-low all-off override |
| therm_fault | input | 1 | Thermal fault, active high, same effect as kill_n=0 |
| zc_strobe | input | 1 | Ringing-current zero-crossing strobe |
| brk_on | output | 1 | Break switch pair control |
| rret_on | output | 1 | Ringing return switch control |
| ring_on | output | 1 | Ringing switch control |
| tst_on | output | 1 | Test switch pair control |
| fault_n | output | 1 | Thermal fault status, low during a fault |

## Verification
The hardest situation to reach from the ports is a ringing switch that is draining while the latch is frozen or an override is active. In that case three mechanisms act on ring_on in the same cycle. The stimulus closes the switch in ringing mode, raises hold_en or drops kill_n, and changes the mode inputs while zc_strobe is withheld for several cycles. It then gives a single strobe, including one that coincides with the turn-off edge. A behavioural reference model runs in the bench, and every output is compared against it on every clock.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    // Mode encoding {ring_sel, test_sel}
    typedef enum logic [1:0] {
        MODE_TALK = 2'b00,
        MODE_TEST = 2'b01,
        MODE_RING = 2'b10,
        MODE_OFF  = 2'b11
    } mode_e;

    localparam int MODE_W = $bits(mode_e);

    // Line state
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_TALK    = 3'd1,
        ST_RING    = 3'd2,
        ST_TEST    = 3'd3,
        ST_BLOCKED = 3'd4
    } line_st_e;

    // Ringing switch state
    typedef enum logic [1:0] {
        RSW_OPEN   = 2'd0,
        RSW_CLOSED = 2'd1,
        RSW_DRAIN  = 2'd2
    } rsw_e;

    typedef struct packed {
        logic brk;
        logic rret;
        logic tst;
    } sw_cmd_t;

endpackage

// File: rtl/lsw_latch.sv
module lsw_latch
    import lsw_pkg::*;
#(
    parameter mode_e RESET_MODE = MODE_OFF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold_en,
    input  mode_e mode_in,
    output mode_e mode_eff
);

    mode_e held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= RESET_MODE;
        end else if (!hold_en) begin
            held_q <= mode_in;
        end
    end

    // Transparent when hold_en is low
    always_comb begin
        mode_eff = hold_en ? held_q : mode_in;
    end

    // While frozen, the effective mode equals what was captured before the freeze
    p_frozen_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_en |-> (mode_eff == held_q));

endmodule

// File: rtl/lsw_mode_fsm.sv
module lsw_mode_fsm
    import lsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mode_e    mode_eff,
    input  logic     block,
    output logic     ring_req,
    output sw_cmd_t  sw_cmd
);

    line_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (block) begin
            st_d = ST_BLOCKED;
        end else begin
            unique case (mode_eff)
                MODE_TALK: st_d = ST_TALK;
                MODE_TEST: st_d = ST_TEST;
                MODE_RING: st_d = ST_RING;
                MODE_OFF:  st_d = ST_OFF;
                default:   st_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Request to the ringing switch machine, aligned with the next state
    always_comb begin
        ring_req = (st_d == ST_RING);
    end

    // Output decode
    always_comb begin
        sw_cmd = '0;
        unique case (st_q)
            ST_TALK:    sw_cmd.brk  = 1'b1;
            ST_RING:    sw_cmd.rret = 1'b1;
            ST_TEST:    sw_cmd.tst  = 1'b1;
            ST_OFF:     sw_cmd      = '0;
            ST_BLOCKED: sw_cmd      = '0;
            default:    sw_cmd      = '0;
        endcase
    end

    // R7: an override always lands in the blocked state
    p_block_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> (st_q == ST_BLOCKED));

    // Only one switch group is ever commanded on
    p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_cmd));

endmodule

// File: rtl/lsw_ring_fsm.sv
module lsw_ring_fsm
    import lsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring_req,
    input  logic zc_strobe,
    output logic ring_on
);

    rsw_e rs_q, rs_d;

    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RSW_OPEN: begin
                if (ring_req) rs_d = RSW_CLOSED;
            end
            RSW_CLOSED: begin
                if (!ring_req) rs_d = zc_strobe ? RSW_OPEN : RSW_DRAIN;
            end
            RSW_DRAIN: begin
                if (ring_req)       rs_d = RSW_CLOSED;
                else if (zc_strobe) rs_d = RSW_OPEN;
            end
            default: rs_d = RSW_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= RSW_OPEN;
        end else begin
            rs_q <= rs_d;
        end
    end

    // Output decode
    always_comb begin
        ring_on = (rs_q != RSW_OPEN);
    end

    // R9: the switch never opens without a zero-crossing strobe
    p_defer_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_on && !zc_strobe) |=> ring_on);

    // R12: a strobe never closes the switch
    p_strobe_inert_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_on && !ring_req) |=> !ring_on);

endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring_sel,
    input  logic test_sel,
    input  logic hold_en,
    input  logic kill_n,
    input  logic therm_fault,
    input  logic zc_strobe,
    output logic brk_on,
    output logic rret_on,
    output logic ring_on,
    output logic tst_on,
    output logic fault_n
);

    mode_e   mode_live;
    mode_e   mode_eff;
    logic    block;
    logic    ring_req;
    sw_cmd_t sw_cmd;
    logic    fault_q;

    always_comb begin
        mode_live = mode_e'({ring_sel, test_sel});
        block     = !kill_n || therm_fault;
    end

    lsw_latch #(
        .RESET_MODE(MODE_OFF)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_en  (hold_en),
        .mode_in  (mode_live),
        .mode_eff (mode_eff)
    );

    lsw_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_eff (mode_eff),
        .block    (block),
        .ring_req (ring_req),
        .sw_cmd   (sw_cmd)
    );

    lsw_ring_fsm u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_req  (ring_req),
        .zc_strobe (zc_strobe),
        .ring_on   (ring_on)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= therm_fault;
        end
    end

    always_comb begin
        brk_on  = sw_cmd.brk;
        rret_on = sw_cmd.rret;
        tst_on  = sw_cmd.tst;
        fault_n = !fault_q;
    end

    // R7: override clears the three directly driven groups
    p_override_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> (!brk_on && !rret_on && !tst_on));

    // R7: nothing closes while overridden
    p_no_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (block && !ring_on) |=> !ring_on);

    // R8: fault flag follows the thermal input
    p_fault_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        therm_fault |=> !fault_n);

    // R1: return switch is only on with the ringing switch closed
    p_rret_with_ring_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rret_on |-> ring_on);

    // R4: test pair excludes break and return switches
    p_test_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tst_on |-> (!brk_on && !rret_on));

    // R6: frozen latch and no override keep break/test/return stable
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && $past(hold_en) && !block && !$past(block))
            |=> ($stable(brk_on) && $stable(rret_on) && $stable(tst_on)));

endmodule

// File: tb/test_line_switch_ctrl.sv
`timescale 1ns/1ps
module test_line_switch_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_sel = 1'b1, test_sel = 1'b1, hold_en = 1'b0;
    logic kill_n = 1'b1, therm_fault = 1'b0, zc_strobe = 1'b0;
    logic brk_on, rret_on, ring_on, tst_on, fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R11";

    // Reference model state
    logic [1:0] m_held = 2'b11;
    logic e_brk = 0, e_rret = 0, e_ring = 0, e_tst = 0, e_fn = 1;

    always #2.5 clk = ~clk;

    line_switch_ctrl i_line_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .ring_sel(ring_sel), .test_sel(test_sel),
        .hold_en(hold_en), .kill_n(kill_n), .therm_fault(therm_fault),
        .zc_strobe(zc_strobe), .brk_on(brk_on), .rret_on(rret_on),
        .ring_on(ring_on), .tst_on(tst_on), .fault_n(fault_n)
    );

    // Behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_held = 2'b11;
            e_brk = 0; e_rret = 0; e_ring = 0; e_tst = 0; e_fn = 1;
        end else begin
            logic [1:0] eff;
            logic blk;
            eff = hold_en ? m_held : {ring_sel, test_sel};
            if (!hold_en) m_held = {ring_sel, test_sel};
            blk = !kill_n || therm_fault;
            e_brk  = !blk && eff == 2'b00;
            e_rret = !blk && eff == 2'b10;
            e_tst  = !blk && eff == 2'b01;
            if (!blk && eff == 2'b10) e_ring = 1;
            else if (e_ring && zc_strobe) e_ring = 0;
            e_fn = !therm_fault;
        end
    end

    task automatic chk(input string req, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "brk_on",  brk_on,  e_brk);
            chk(cur_req, "rret_on", rret_on, e_rret);
            chk(cur_req, "ring_on", ring_on, e_ring);
            chk(cur_req, "tst_on",  tst_on,  e_tst);
            chk(cur_req, "fault_n", fault_n, e_fn);
        end
    end

    task automatic drive(input string req, input logic [1:0] mode, input logic hold,
                         input logic kill, input logic flt, input logic zc, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur_req = req;
            {ring_sel, test_sel} = mode;
            hold_en = hold; kill_n = kill; therm_fault = flt; zc_strobe = zc;
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R11";
        chk("R11", "reset brk_on", brk_on, 1'b0);
        chk("R11", "reset ring_on", ring_on, 1'b0);
        chk("R11", "reset fault_n", fault_n, 1'b1);
        rst_n = 1'b1;
        drive("R11", 2'b11, 1, 1, 0, 0, 3);        // held mode must be all-off
        drive("R2",  2'b00, 0, 1, 0, 0, 3);
        drive("R4",  2'b01, 0, 1, 0, 0, 3);
        drive("R12", 2'b00, 0, 1, 0, 1, 3);
        drive("R1",  2'b10, 0, 1, 0, 0, 3);
        drive("R10", 2'b00, 0, 1, 0, 0, 4);
        @(negedge clk);
        chk("R10", "mbb brk_on", brk_on, 1'b1);
        chk("R10", "mbb ring_on", ring_on, 1'b1);
        drive("R9",  2'b00, 0, 1, 0, 1, 1);
        drive("R9",  2'b00, 0, 1, 0, 0, 2);
        drive("R1",  2'b10, 0, 1, 0, 0, 2);
        drive("R3",  2'b11, 0, 1, 0, 0, 4);
        drive("R3",  2'b11, 0, 1, 0, 1, 1);
        drive("R3",  2'b11, 0, 1, 0, 0, 2);
        // Strobe coinciding with the turn-off edge
        drive("R1",  2'b10, 0, 1, 0, 0, 2);
        drive("R9",  2'b01, 0, 1, 0, 1, 1);
        drive("R9",  2'b01, 0, 1, 0, 0, 2);
        // Transparent latch, changing every cycle
        for (int k = 0; k < 12; k++) drive("R5", k[1:0] ^ 2'b01, 0, 1, 0, k[2], 1);
        // Frozen latch in ringing mode
        drive("R6",  2'b10, 0, 1, 0, 0, 2);
        drive("R6",  2'b00, 1, 1, 0, 0, 2);
        drive("R6",  2'b01, 1, 1, 0, 1, 2);
        drive("R6",  2'b11, 1, 1, 0, 0, 2);
        drive("R6",  2'b00, 0, 1, 0, 0, 2);
        drive("R6",  2'b00, 0, 1, 0, 1, 1);
        drive("R6",  2'b01, 1, 1, 0, 0, 3);
        // Kill override over a frozen ringing latch
        drive("R7",  2'b10, 0, 1, 0, 0, 2);
        drive("R7",  2'b10, 1, 0, 0, 0, 3);
        drive("R7",  2'b00, 1, 0, 0, 1, 1);
        drive("R7",  2'b01, 0, 0, 0, 0, 3);
        drive("R7",  2'b10, 0, 0, 0, 0, 2);
        drive("R7",  2'b10, 0, 1, 0, 0, 2);
        // Thermal fault
        drive("R8",  2'b00, 0, 1, 1, 0, 3);
        drive("R8",  2'b10, 0, 1, 1, 0, 2);
        drive("R8",  2'b10, 0, 1, 0, 0, 2);
        drive("R8",  2'b10, 0, 1, 1, 0, 3);
        drive("R8",  2'b10, 0, 1, 1, 1, 1);
        drive("R8",  2'b00, 0, 1, 0, 0, 3);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule